// File: doc/BRIEF.md
# Flash Status Register Two

This block keeps the second eight-bit status byte of a serial NOR flash device. Several kinds of bit share the byte, and each kind follows its own update rule. One flag records whether an erase or program operation has been suspended. Three one-time-programmable lock bits guard three 256-byte security areas. One fixed quad-enable bit always reads as one. Two plain writable control bits hold complement protect and status-register lock.

A command decoder outside the block drives one-cycle strobes: suspend, resume, and write-status-register-two, the last with a data byte. Each register samples a strobe on the rising clock edge, and the new value appears on the status output from that edge onward. A separate index input selects one of the security areas. A combinational flag then reports whether that area may still be written.

The suspend flag is a two-state machine. Its states are `SUS_RUNNING` and `SUS_HALTED`. The suspend strobe takes it from `SUS_RUNNING` to `SUS_HALTED`. The resume strobe takes it from `SUS_HALTED` to `SUS_RUNNING`. Power-on reset forces `SUS_RUNNING`.

Each lock bit is a two-state machine with states `LK_OPEN` and `LK_SEALED`. A write whose data bit for that lock is one takes it from `LK_OPEN` to `LK_SEALED`. No transition leaves `LK_SEALED`.

Top module: `flash_sr2`

## Requirements
- R1: The status byte is laid out as follows. Bit 7 is the suspend flag and bit 6 is complement protect. Bits 5, 4 and 3 are the locks for security areas 3, 2 and 1. Bit 2 is reserved and always reads 0. Bit 1 is quad enable and always reads 1. Bit 0 is status-register lock.
- R2: A suspend strobe sets bit 7 at the next rising edge. A suspend strobe while bit 7 is already 1 leaves it at 1.
- R3: A resume strobe clears bit 7 at the next rising edge. A resume strobe while bit 7 is 0 has no effect. When suspend and resume arrive in the same cycle, resume wins and bit 7 becomes 0.
- R4: While the active-low power-on reset is low, bits 7, 6 and 0 read 0.
- R5: A write strobe loads data bit 6 into bit 6 and data bit 0 into bit 0 at the next rising edge.
- R6: A write strobe ORs data bits 5..3 into the lock bits at the next rising edge. Each lock bit starts at 0 and can be set on its own. Once set, a lock bit never returns to 0, whether by a write or by power-on reset.
- R7: A write strobe never changes bits 7, 2 or 1, whatever the data byte holds.
- R8: The write-allowed output is combinational. For index values 1 to 3 it is the inverse of that area's lock bit: area 1 is bit 3, area 2 is bit 4, area 3 is bit 5. For index 0 it is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Active-low power-on reset, asynchronous |
| suspend_stb | input | 1 | Erase/program suspend command strobe |
| resume_stb | input | 1 | Erase/program resume command strobe |
| wrsr_stb | input | 1 | Write status register two strobe |
| wrsr_data | input | 8 | Data byte for the write strobe |
| area_idx | input | 2 | Security area index (1 to 3; 0 is invalid) |
| status_byte | output | 8 | Current status register two value |
| area_wr_ok | output | 1 | Selected security area may be written |

## Verification
A wrong suspend state appears on bit 7 of the status output one edge after the strobe that caused it. A lock bit that fails to set, or falls back to 0, changes both the status byte and the write-allowed flag for its area. The flag responds within the same cycle the index changes. A lock that power-on reset wrongly clears is caught at the first sample after reset is released. A sweep of the write data byte in both suspend states shows any leak into the fixed or status-only bits at the next edge.

// File: rtl/flash_sr2_pkg.sv
package flash_sr2_pkg;

    localparam int SR_W       = 8;
    localparam int LOCK_N     = 3;
    localparam int IDX_W      = 2;

    localparam int POS_SRL    = 0;
    localparam int POS_QE     = 1;
    localparam int POS_RSV    = 2;
    localparam int POS_LK_LO  = 3;
    localparam int POS_LK_HI  = POS_LK_LO + LOCK_N - 1;
    localparam int POS_CMP    = 6;
    localparam int POS_SUS    = 7;

    typedef enum logic {
        SUS_RUNNING = 1'b0,
        SUS_HALTED  = 1'b1
    } sus_state_e;

    typedef enum logic {
        LK_OPEN   = 1'b0,
        LK_SEALED = 1'b1
    } lock_state_e;

endpackage

// File: rtl/flash_sr2_suspend_fsm.sv
module flash_sr2_suspend_fsm
    import flash_sr2_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic suspend_stb,
    input  logic resume_stb,
    output logic sus_flag
);

    sus_state_e state_q;
    sus_state_e state_d;

    // Next-state logic: resume has priority over suspend.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SUS_RUNNING: if (suspend_stb && !resume_stb) state_d = SUS_HALTED;
            SUS_HALTED:  if (resume_stb)                 state_d = SUS_RUNNING;
            default:                                     state_d = SUS_RUNNING;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= SUS_RUNNING;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            SUS_HALTED: sus_flag = 1'b1;
            default:    sus_flag = 1'b0;
        endcase
    end

endmodule

// File: rtl/flash_sr2_otp_locks.sv
module flash_sr2_otp_locks
    import flash_sr2_pkg::*;
#(
    parameter int N = LOCK_N
) (
    input  logic         clk,
    input  logic         wr_stb,
    input  logic [N-1:0] wr_bits,
    output logic [N-1:0] locked
);

    // Non-volatile model: no reset input, starts erased (open).
    for (genvar g = 0; g < N; g++) begin : g_lock
        lock_state_e st_q = LK_OPEN;
        lock_state_e st_d;

        always_comb begin
            st_d = st_q;
            unique case (st_q)
                LK_OPEN:   if (wr_stb && wr_bits[g]) st_d = LK_SEALED;
                LK_SEALED:                           st_d = LK_SEALED;
                default:                             st_d = LK_SEALED;
            endcase
        end

        always_ff @(posedge clk) begin
            st_q <= st_d;
        end

        always_comb begin
            unique case (st_q)
                LK_SEALED: locked[g] = 1'b1;
                default:   locked[g] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/flash_sr2_cfg_bits.sv
module flash_sr2_cfg_bits
    import flash_sr2_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic wr_stb,
    input  logic cmp_in,
    input  logic srl_in,
    output logic cmp_q,
    output logic srl_q
);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cmp_q <= 1'b0;
            srl_q <= 1'b0;
        end else if (wr_stb) begin
            cmp_q <= cmp_in;
            srl_q <= srl_in;
        end
    end

endmodule

// File: rtl/flash_sr2_area_gate.sv
module flash_sr2_area_gate
    import flash_sr2_pkg::*;
#(
    parameter int N = LOCK_N,
    parameter int W = IDX_W
) (
    input  logic [W-1:0] idx,
    input  logic [N-1:0] locked,
    output logic         wr_ok
);

    // Index 0 is invalid; index k maps to lock k-1.
    always_comb begin
        wr_ok = 1'b0;
        for (int k = 1; k <= N; k++) begin
            if (idx == W'(k)) wr_ok = !locked[k-1];
        end
    end

endmodule

// File: rtl/flash_sr2.sv
module flash_sr2
    import flash_sr2_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic             suspend_stb,
    input  logic             resume_stb,
    input  logic             wrsr_stb,
    input  logic [SR_W-1:0]  wrsr_data,
    input  logic [IDX_W-1:0] area_idx,
    output logic [SR_W-1:0]  status_byte,
    output logic             area_wr_ok
);

    logic              sus_flag;
    logic              cmp_q;
    logic              srl_q;
    logic [LOCK_N-1:0] locked;

    flash_sr2_suspend_fsm u_sus (
        .clk         (clk),
        .por_n       (por_n),
        .suspend_stb (suspend_stb),
        .resume_stb  (resume_stb),
        .sus_flag    (sus_flag)
    );

    flash_sr2_otp_locks #(.N(LOCK_N)) u_locks (
        .clk     (clk),
        .wr_stb  (wrsr_stb),
        .wr_bits (wrsr_data[POS_LK_HI:POS_LK_LO]),
        .locked  (locked)
    );

    flash_sr2_cfg_bits u_cfg (
        .clk    (clk),
        .por_n  (por_n),
        .wr_stb (wrsr_stb),
        .cmp_in (wrsr_data[POS_CMP]),
        .srl_in (wrsr_data[POS_SRL]),
        .cmp_q  (cmp_q),
        .srl_q  (srl_q)
    );

    flash_sr2_area_gate #(.N(LOCK_N), .W(IDX_W)) u_gate (
        .idx    (area_idx),
        .locked (locked),
        .wr_ok  (area_wr_ok)
    );

    always_comb begin
        status_byte                    = '0;
        status_byte[POS_SUS]           = sus_flag;
        status_byte[POS_CMP]           = cmp_q;
        status_byte[POS_LK_HI:POS_LK_LO] = locked;
        status_byte[POS_RSV]           = 1'b0;
        status_byte[POS_QE]            = 1'b1;
        status_byte[POS_SRL]           = srl_q;
    end

endmodule

// File: rtl/flash_sr2_chk.sv
module flash_sr2_chk (
    input logic       clk,
    input logic       por_n,
    input logic       suspend_stb,
    input logic       resume_stb,
    input logic       wrsr_stb,
    input logic [7:0] wrsr_data,
    input logic [1:0] area_idx,
    input logic [7:0] status_byte,
    input logic       area_wr_ok
);

    AST_FIXED_BITS: assert property (@(posedge clk) disable iff (!por_n)
        status_byte[1] && !status_byte[2]); // R1

    AST_SUS_SET: assert property (@(posedge clk) disable iff (!por_n)
        suspend_stb && !resume_stb |=> status_byte[7]); // R2

    AST_SUS_CLEAR: assert property (@(posedge clk) disable iff (!por_n)
        resume_stb |=> !status_byte[7]); // R3

    AST_POR_CLEAR: assert property (@(posedge clk)
        !por_n |-> (status_byte[7] == 1'b0 && status_byte[6] == 1'b0 && status_byte[0] == 1'b0)); // R4

    AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!por_n)
        wrsr_stb |=> (status_byte[6] == $past(wrsr_data[6]) && status_byte[0] == $past(wrsr_data[0]))); // R5

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        wrsr_stb |=> ((status_byte[5:3] & $past(wrsr_data[5:3])) == $past(wrsr_data[5:3]))); // R6

    AST_WR_KEEPS_SUS: assert property (@(posedge clk) disable iff (!por_n)
        wrsr_stb && !suspend_stb && !resume_stb |=> status_byte[7] == $past(status_byte[7])); // R7

    AST_IDX0_DENY: assert property (@(posedge clk) disable iff (!por_n)
        area_idx == 2'd0 |-> !area_wr_ok); // R8

endmodule

bind flash_sr2 flash_sr2_chk u_chk (
    .clk         (clk),
    .por_n       (por_n),
    .suspend_stb (suspend_stb),
    .resume_stb  (resume_stb),
    .wrsr_stb    (wrsr_stb),
    .wrsr_data   (wrsr_data),
    .area_idx    (area_idx),
    .status_byte (status_byte),
    .area_wr_ok  (area_wr_ok)
);

// File: tb/flash_sr2_test.sv
module flash_sr2_test;

    logic       clk = 1'b0;
    logic       por_n;
    logic       suspend_stb;
    logic       resume_stb;
    logic       wrsr_stb;
    logic [7:0] wrsr_data;
    logic [1:0] area_idx;
    logic [7:0] status_byte;
    logic       area_wr_ok;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic       m_sus = 1'b0;
    logic       m_cmp = 1'b0;
    logic       m_srl = 1'b0;
    logic [2:0] m_lock = 3'b000;

    always #10 clk = ~clk; // 50 MHz

    flash_sr2 uut (
        .clk         (clk),
        .por_n       (por_n),
        .suspend_stb (suspend_stb),
        .resume_stb  (resume_stb),
        .wrsr_stb    (wrsr_stb),
        .wrsr_data   (wrsr_data),
        .area_idx    (area_idx),
        .status_byte (status_byte),
        .area_wr_ok  (area_wr_ok)
    );

    function automatic logic [7:0] exp_byte();
        return {m_sus, m_cmp, m_lock, 1'b0, 1'b1, m_srl};
    endfunction

    task automatic check_byte(input string req);
        tests++;
        if (status_byte !== exp_byte()) begin
            fails++;
            $display("FAIL %s status actual=%02h expected=%02h", req, status_byte, exp_byte());
        end
    endtask

    task automatic check_gate(input string req);
        for (int i = 0; i < 4; i++) begin
            logic e;
            area_idx = 2'(i);
            #1;
            e = (i == 0) ? 1'b0 : !m_lock[i-1];
            tests++;
            if (area_wr_ok !== e) begin
                fails++;
                $display("FAIL %s wr_ok idx=%0d actual=%b expected=%b", req, i, area_wr_ok, e);
            end
        end
    endtask

    // Drive at negedge, model updates at edge, compare at next negedge.
    task automatic cycle(input logic s, input logic r, input logic w, input logic [7:0] d);
        @(negedge clk);
        suspend_stb = s; resume_stb = r; wrsr_stb = w; wrsr_data = d;
        @(posedge clk);
        if (r)      m_sus = 1'b0;
        else if (s) m_sus = 1'b1;
        if (w) begin
            m_cmp  = d[6];
            m_srl  = d[0];
            m_lock = m_lock | d[5:3];
        end
        @(negedge clk);
        suspend_stb = 0; resume_stb = 0; wrsr_stb = 0; wrsr_data = 8'h00;
    endtask

    task automatic do_reset();
        @(negedge clk);
        por_n = 1'b0;
        m_sus = 1'b0; m_cmp = 1'b0; m_srl = 1'b0;
        #2;
        check_byte("R4");
        @(negedge clk);
        por_n = 1'b1;
    endtask

    initial begin
        por_n = 1'b0; suspend_stb = 0; resume_stb = 0; wrsr_stb = 0;
        wrsr_data = 8'h00; area_idx = 2'd0;
        #1;
        check_byte("R4");
        repeat (2) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        check_byte("R1");
        check_gate("R8");

        // R2, R3: suspend flag sequences
        cycle(0, 1, 0, 8'h00); check_byte("R3");
        cycle(1, 0, 0, 8'h00); check_byte("R2");
        cycle(1, 0, 0, 8'h00); check_byte("R2");
        cycle(0, 1, 0, 8'h00); check_byte("R3");
        cycle(0, 1, 0, 8'h00); check_byte("R3");
        cycle(1, 0, 0, 8'h00); check_byte("R2");
        cycle(1, 1, 0, 8'h00); check_byte("R3");

        // R5, R7: sweep non-lock data bits in both suspend states
        for (int sus = 0; sus < 2; sus++) begin
            if (sus == 1) begin cycle(1, 0, 0, 8'h00); check_byte("R2"); end
            for (int v = 0; v < 256; v++) begin
                logic [7:0] d;
                d = 8'(v) & 8'hC7;
                cycle(0, 0, 1, d);
                check_byte("R5");
                check_byte("R7");
            end
        end

        // R4: reset mid-state keeps nothing but locks
        cycle(0, 0, 1, 8'h41);
        do_reset();
        @(negedge clk);
        check_byte("R4");

        // R6, R8: seal areas one at a time, reset between
        for (int k = 0; k < 3; k++) begin
            cycle(0, 0, 1, 8'(1 << (3 + k)));
            check_byte("R6");
            check_gate("R8");
            cycle(0, 0, 1, 8'h00);
            check_byte("R6");
            do_reset();
            @(negedge clk);
            check_byte("R6");
            check_gate("R8");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #5_000_000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule